// File: doc/BRIEF.md
# MEI Snoop Response Controller

This block decides how a data cache reacts when another bus agent's transaction is snooped. The cache keeps each block in one of three coherency states: modified, exclusive or invalid. For each snooped transaction the block takes four inputs: a 5-bit transfer-type code, the snooped address, the burst and caching-inhibited attributes, and the tag lookup result. It returns the new state to write back to the tag array and an address-retry pulse. When a modified block must leave the cache, it also raises a push request that stays up until the push datapath acknowledges it.

The block also holds one load-reserve/store-conditional reservation, kept as a cache-block address. The local core sets the reservation with a load-reserve strobe and clears it with a store-conditional strobe. Some snooped transactions cancel it: one kind only when its block address matches, another kind regardless of address. The tag array, the data array and the push datapath are outside the block. They connect through plain ports.

Top module: `mei_snoop_ctrl`

## Requirements
- R1: The transfer-type codes are decoded as follows:
   - 00110: write-with-kill.
   - 01010: read.
   - 01110: read-with-intent-to-modify.
   - 10010: write-with-flush-atomic.
   - 11010: atomic read.
   - 11110: atomic read-with-intent-to-modify.
   - Any other code, including 10110, 00011 and 00111, produces no state update, no address-retry, no push request and no change to the reservation.
- R2: On write-with-kill, a hit moves the block to invalid (upd_state 00) whether it was exclusive or modified. It asserts neither address-retry nor a push request, so modified data is discarded.
- R3: Write-with-kill cancels the reservation only when its block address equals the reserved block address. The comparison ignores the low log2(BLK_BYTES) address bits. A different block leaves the reservation valid and unchanged.
- R4: On a read that is single-beat (snp_burst=0) and caching-inhibited (snp_inhibit=1):
   - An exclusive block stays exclusive (upd_state 01).
   - A modified block asserts address-retry, requests a push, and moves to exclusive.
- R5: On any other read (burst, or cacheable):
   - An exclusive block moves to invalid.
   - A modified block asserts address-retry, requests a push, and moves to invalid.
- R6: Read-with-intent-to-modify and write-with-flush-atomic both move exclusive to invalid. For a modified block they assert address-retry, request a push and move to invalid.
- R7: Atomic read (11010) responds exactly as read. Atomic read-with-intent-to-modify (11110) responds exactly as read-with-intent-to-modify.
- R8: Write-with-flush-atomic cancels a held reservation whatever the snooped address is.
- R9: A miss produces no state update, no address-retry and no push request. A miss is tag_hit=0, or a tag state that is neither exclusive (01) nor modified (11); 00 and 10 count as invalid.
- R10: Timing of the outputs:
   - upd_valid, upd_state and addr_retry appear in the cycle after the snoop is sampled.
   - addr_retry lasts one cycle per snoop and only ever accompanies a push request.
   - push_req rises together with addr_retry and stays high until push_ack is sampled, then falls in the next cycle.
   - A snoop never sets a block to modified.
- R11: Updates to the reservation:
   - lr_valid sets the reservation to the block of lr_addr, and takes priority over a same-cycle cancel.
   - sc_valid clears the reservation.
   - Read and read-with-intent-to-modify snoops leave the reservation untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_ttype | input | 5 | Transfer-type code |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_burst | input | 1 | 1 = burst, 0 = single-beat |
| snp_inhibit | input | 1 | 1 = caching-inhibited |
| tag_hit | input | 1 | Tag lookup hit |
| tag_state | input | 2 | Current block state: 00 invalid, 01 exclusive, 11 modified |
| upd_valid | output | 1 | Write upd_state to the tag array |
| upd_state | output | 2 | New block state |
| addr_retry | output | 1 | Address-retry pulse |
| push_req | output | 1 | Push modified block request, held until acknowledged |
| push_ack | input | 1 | Push datapath acknowledge |
| lr_valid | input | 1 | Local load-reserve |
| lr_addr | input | ADDR_W | Load-reserve byte address |
| sc_valid | input | 1 | Local store-conditional |
| resv_valid | output | 1 | Reservation held |
| resv_blk | output | ADDR_W-log2(BLK_BYTES) | Reserved block address |

## Verification
The embedded properties check the following on every cycle:
- A kill hit always yields invalid with no retry.
- A miss or reserved code stays silent.
- No update ever grants the modified state.
- Retry never appears without a push request.
- A push request holds until it is acknowledged.
- A flush, a load-reserve or a store-conditional has the expected effect on the reservation.

Only the directed scenarios show the rest:
- The distinction between single-beat inhibited reads and other reads.
- The aliasing of the atomic codes.
- Block-granular address matching for kill cancellation.
- That read-type snoops and reserved codes leave an existing reservation intact.

// File: rtl/mei_snoop_pkg.sv
package mei_snoop_pkg;

   localparam logic [1:0] ST_I = 2'b00;
   localparam logic [1:0] ST_E = 2'b01;
   localparam logic [1:0] ST_M = 2'b11;

   localparam logic [4:0] TT_KILL    = 5'b00110;
   localparam logic [4:0] TT_READ    = 5'b01010;
   localparam logic [4:0] TT_RWITM   = 5'b01110;
   localparam logic [4:0] TT_FLUSH   = 5'b10010;
   localparam logic [4:0] TT_READ_A  = 5'b11010;
   localparam logic [4:0] TT_RWITM_A = 5'b11110;

   typedef enum logic [2:0] {
      K_NONE,
      K_KILL,
      K_READ,
      K_RWITM,
      K_FLUSH
   } snp_kind_e;

   typedef struct packed {
      logic       upd;
      logic [1:0] nxt;
      logic       retry;
      logic       push;
   } snp_resp_t;

endpackage

// File: rtl/mei_snoop_decode.sv
module mei_snoop_decode
   import mei_snoop_pkg::*;
#(
   parameter bit ALIAS_ATOMIC = 1'b1
) (
   input  logic [4:0] ttype,
   output snp_kind_e  kind
);

   snp_kind_e atom_kind;

   generate
      if (ALIAS_ATOMIC) begin : g_alias
         always_comb begin
            if (ttype == TT_READ_A)       atom_kind = K_READ;
            else if (ttype == TT_RWITM_A) atom_kind = K_RWITM;
            else                          atom_kind = K_NONE;
         end
      end else begin : g_strict
         assign atom_kind = K_NONE;
      end
   endgenerate

   always_comb begin
      case (ttype)
         TT_KILL:  kind = K_KILL;
         TT_READ:  kind = K_READ;
         TT_RWITM: kind = K_RWITM;
         TT_FLUSH: kind = K_FLUSH;
         default:  kind = atom_kind;
      endcase
   end

endmodule

// File: rtl/mei_snoop_resp.sv
module mei_snoop_resp
   import mei_snoop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       snp_valid,
   input  snp_kind_e  kind,
   input  logic       burst,
   input  logic       inhibit,
   input  logic       tag_hit,
   input  logic [1:0] tag_state,
   input  logic       push_ack,
   output logic       upd_valid,
   output logic [1:0] upd_state,
   output logic       addr_retry,
   output logic       push_req
);

   logic      live;
   logic      is_mod;
   snp_resp_t rsp;

   assign is_mod = (tag_state == ST_M);
   assign live   = tag_hit && ((tag_state == ST_E) || is_mod);

   always_comb begin
      rsp = '{upd: 1'b0, nxt: ST_I, retry: 1'b0, push: 1'b0};
      if (live) begin
         case (kind)
            K_KILL: begin
               rsp.upd = 1'b1;
               rsp.nxt = ST_I;
            end
            K_READ: begin
               rsp.upd   = 1'b1;
               rsp.nxt   = (!burst && inhibit) ? ST_E : ST_I;
               rsp.retry = is_mod;
               rsp.push  = is_mod;
            end
            K_RWITM, K_FLUSH: begin
               rsp.upd   = 1'b1;
               rsp.nxt   = ST_I;
               rsp.retry = is_mod;
               rsp.push  = is_mod;
            end
            default: rsp = '{upd: 1'b0, nxt: ST_I, retry: 1'b0, push: 1'b0};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_valid  <= 1'b0;
         upd_state  <= ST_I;
         addr_retry <= 1'b0;
         push_req   <= 1'b0;
      end else begin
         upd_valid  <= snp_valid && rsp.upd;
         upd_state  <= snp_valid ? rsp.nxt : ST_I;
         addr_retry <= snp_valid && rsp.retry;
         push_req   <= (snp_valid && rsp.push) || (push_req && !push_ack);
      end
   end

   // R2
   a_r2_kill_to_inv: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && kind == K_KILL && live |=> upd_valid && upd_state == ST_I && !addr_retry);
   // R9
   a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && !live |=> !upd_valid && !addr_retry);
   // R1
   a_r1_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && kind == K_NONE |=> !upd_valid && !addr_retry);
   // R10
   a_r10_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !push_ack |=> push_req);
   a_r10_retry_with_push: assert property (@(posedge clk) disable iff (!rst_n)
      addr_retry |-> push_req);
   a_r10_never_grant_m: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> upd_state != ST_M);

endmodule

// File: rtl/mei_resv_track.sv
module mei_resv_track
   import mei_snoop_pkg::*;
#(
   parameter int BLK_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snp_valid,
   input  snp_kind_e        kind,
   input  logic [BLK_W-1:0] snp_blk,
   input  logic             lr_valid,
   input  logic [BLK_W-1:0] lr_blk,
   input  logic             sc_valid,
   output logic             resv_valid,
   output logic [BLK_W-1:0] resv_blk
);

   logic kill_hit;
   logic cancel;

   assign kill_hit = (kind == K_KILL) && (snp_blk == resv_blk);
   assign cancel   = sc_valid || (snp_valid && (kill_hit || kind == K_FLUSH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_blk   <= '0;
      end else if (lr_valid) begin
         resv_valid <= 1'b1;
         resv_blk   <= lr_blk;
      end else if (cancel) begin
         resv_valid <= 1'b0;
      end
   end

   // R8
   a_r8_flush_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && kind == K_FLUSH && !lr_valid |=> !resv_valid);
   // R11
   a_r11_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid && !lr_valid |=> !resv_valid);
   a_r11_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      lr_valid |=> resv_valid && resv_blk == $past(lr_blk));
   // R3
   a_r3_kill_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && kind == K_KILL && snp_blk != resv_blk && !sc_valid && !lr_valid
      |=> resv_valid == $past(resv_valid));

endmodule

// File: rtl/mei_snoop_ctrl.sv
module mei_snoop_ctrl
   import mei_snoop_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int BLK_BYTES    = 32,
   parameter bit ALIAS_ATOMIC = 1'b1,
   localparam int BLK_OFF     = $clog2(BLK_BYTES),
   localparam int BLK_W       = ADDR_W - BLK_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [4:0]        snp_ttype,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_burst,
   input  logic              snp_inhibit,
   input  logic              tag_hit,
   input  logic [1:0]        tag_state,
   output logic              upd_valid,
   output logic [1:0]        upd_state,
   output logic              addr_retry,
   output logic              push_req,
   input  logic              push_ack,
   input  logic              lr_valid,
   input  logic [ADDR_W-1:0] lr_addr,
   input  logic              sc_valid,
   output logic              resv_valid,
   output logic [BLK_W-1:0]  resv_blk
);

   generate
      if ((1 << BLK_OFF) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if (BLK_OFF >= ADDR_W) begin : g_bad_addr
         $error("block offset must be narrower than the address");
      end
      if (BLK_OFF > 0) begin : g_lo
         logic unused_lo;
         assign unused_lo = ^{snp_addr[BLK_OFF-1:0], lr_addr[BLK_OFF-1:0]};
      end
   endgenerate

   snp_kind_e kind;

   mei_snoop_decode #(.ALIAS_ATOMIC(ALIAS_ATOMIC)) decode_i (
      .ttype (snp_ttype),
      .kind  (kind)
   );

   mei_snoop_resp resp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .snp_valid  (snp_valid),
      .kind       (kind),
      .burst      (snp_burst),
      .inhibit    (snp_inhibit),
      .tag_hit    (tag_hit),
      .tag_state  (tag_state),
      .push_ack   (push_ack),
      .upd_valid  (upd_valid),
      .upd_state  (upd_state),
      .addr_retry (addr_retry),
      .push_req   (push_req)
   );

   mei_resv_track #(.BLK_W(BLK_W)) resv_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .snp_valid  (snp_valid),
      .kind       (kind),
      .snp_blk    (snp_addr[ADDR_W-1:BLK_OFF]),
      .lr_valid   (lr_valid),
      .lr_blk     (lr_addr[ADDR_W-1:BLK_OFF]),
      .sc_valid   (sc_valid),
      .resv_valid (resv_valid),
      .resv_blk   (resv_blk)
   );

endmodule

// File: tb/mei_snoop_ctrl_tb_top.sv
module mei_snoop_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snp_valid = 1'b0;
   logic [4:0]  snp_ttype = '0;
   logic [31:0] snp_addr = '0;
   logic        snp_burst = 1'b0;
   logic        snp_inhibit = 1'b0;
   logic        tag_hit = 1'b0;
   logic [1:0]  tag_state = 2'b00;
   logic        upd_valid;
   logic [1:0]  upd_state;
   logic        addr_retry;
   logic        push_req;
   logic        push_ack = 1'b0;
   logic        lr_valid = 1'b0;
   logic [31:0] lr_addr = '0;
   logic        sc_valid = 1'b0;
   logic        resv_valid;
   logic [26:0] resv_blk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mei_snoop_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ttype(snp_ttype),
      .snp_addr(snp_addr), .snp_burst(snp_burst), .snp_inhibit(snp_inhibit),
      .tag_hit(tag_hit), .tag_state(tag_state), .upd_valid(upd_valid),
      .upd_state(upd_state), .addr_retry(addr_retry), .push_req(push_req),
      .push_ack(push_ack), .lr_valid(lr_valid), .lr_addr(lr_addr),
      .sc_valid(sc_valid), .resv_valid(resv_valid), .resv_blk(resv_blk)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one-cycle snoop; returns at the negedge where registered outputs are visible
   task automatic snoop(logic [4:0] tt, logic [31:0] a, logic b, logic ci,
                        logic hit, logic [1:0] st);
      @(negedge clk);
      snp_valid = 1'b1; snp_ttype = tt; snp_addr = a;
      snp_burst = b; snp_inhibit = ci; tag_hit = hit; tag_state = st;
      @(negedge clk);
      snp_valid = 1'b0; tag_hit = 1'b0;
   endtask

   task automatic expect_resp(string req, logic upd, logic [1:0] st,
                              logic retry, logic push);
      chk(req, "upd_valid", 32'(upd_valid), 32'(upd));
      if (upd) chk(req, "upd_state", 32'(upd_state), 32'(st));
      chk(req, "addr_retry", 32'(addr_retry), 32'(retry));
      chk(req, "push_req", 32'(push_req), 32'(push));
   endtask

   task automatic ack_push(string req);
      @(negedge clk);
      chk(req, "retry pulse end", 32'(addr_retry), 32'd0);
      chk(req, "push held", 32'(push_req), 32'd1);
      push_ack = 1'b1;
      @(negedge clk);
      push_ack = 1'b0;
      chk(req, "push dropped", 32'(push_req), 32'd0);
   endtask

   task automatic reserve(logic [31:0] a);
      @(negedge clk);
      lr_valid = 1'b1; lr_addr = a;
      @(negedge clk);
      lr_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10", "reset upd_valid", 32'(upd_valid), 32'd0);
      chk("R10", "reset retry", 32'(addr_retry), 32'd0);
      chk("R10", "reset push", 32'(push_req), 32'd0);
      chk("R11", "reset resv", 32'(resv_valid), 32'd0);
   endtask

   task automatic t_kill();
      snoop(5'b00110, 32'h2000_0000, 1'b1, 1'b0, 1'b1, 2'b11);
      expect_resp("R2", 1'b1, 2'b00, 1'b0, 1'b0);
      snoop(5'b00110, 32'h2000_0000, 1'b1, 1'b0, 1'b1, 2'b01);
      expect_resp("R2", 1'b1, 2'b00, 1'b0, 1'b0);
   endtask

   task automatic t_kill_resv();
      reserve(32'h1000_0040);
      chk("R11", "lr sets", 32'(resv_valid), 32'd1);
      chk("R11", "lr blk", 32'(resv_blk), 32'h1000_0040 >> 5);
      snoop(5'b00110, 32'h1000_0060, 1'b1, 1'b0, 1'b0, 2'b00);
      chk("R3", "other block keeps", 32'(resv_valid), 32'd1);
      snoop(5'b00110, 32'h1000_005C, 1'b1, 1'b0, 1'b0, 2'b00);
      chk("R3", "same block cancels", 32'(resv_valid), 32'd0);
   endtask

   task automatic t_read_ci();
      snoop(5'b01010, 32'h3000_0000, 1'b0, 1'b1, 1'b1, 2'b01);
      expect_resp("R4", 1'b1, 2'b01, 1'b0, 1'b0);
      snoop(5'b01010, 32'h3000_0000, 1'b0, 1'b1, 1'b1, 2'b11);
      expect_resp("R4", 1'b1, 2'b01, 1'b1, 1'b1);
      ack_push("R10");
   endtask

   task automatic t_read_other();
      snoop(5'b01010, 32'h3000_0020, 1'b1, 1'b0, 1'b1, 2'b01);
      expect_resp("R5", 1'b1, 2'b00, 1'b0, 1'b0);
      snoop(5'b01010, 32'h3000_0020, 1'b0, 1'b0, 1'b1, 2'b01);
      expect_resp("R5", 1'b1, 2'b00, 1'b0, 1'b0);
      snoop(5'b01010, 32'h3000_0020, 1'b1, 1'b1, 1'b1, 2'b11);
      expect_resp("R5", 1'b1, 2'b00, 1'b1, 1'b1);
      ack_push("R5");
   endtask

   task automatic t_rwitm();
      reserve(32'h4000_0000);
      snoop(5'b01110, 32'h4000_0000, 1'b1, 1'b0, 1'b1, 2'b11);
      expect_resp("R6", 1'b1, 2'b00, 1'b1, 1'b1);
      chk("R11", "rwitm keeps resv", 32'(resv_valid), 32'd1);
      ack_push("R6");
      snoop(5'b01010, 32'h4000_0000, 1'b1, 1'b0, 1'b1, 2'b01);
      chk("R11", "read keeps resv", 32'(resv_valid), 32'd1);
   endtask

   task automatic t_flush();
      snoop(5'b10010, 32'h5555_0000, 1'b1, 1'b0, 1'b1, 2'b01);
      expect_resp("R6", 1'b1, 2'b00, 1'b0, 1'b0);
      chk("R8", "flush cancels any addr", 32'(resv_valid), 32'd0);
      snoop(5'b10010, 32'h5555_0000, 1'b1, 1'b0, 1'b1, 2'b11);
      expect_resp("R6", 1'b1, 2'b00, 1'b1, 1'b1);
      ack_push("R6");
   endtask

   task automatic t_atomic();
      snoop(5'b11010, 32'h6000_0000, 1'b0, 1'b1, 1'b1, 2'b11);
      expect_resp("R7", 1'b1, 2'b01, 1'b1, 1'b1);
      ack_push("R7");
      snoop(5'b11110, 32'h6000_0000, 1'b0, 1'b1, 1'b1, 2'b01);
      expect_resp("R7", 1'b1, 2'b00, 1'b0, 1'b0);
   endtask

   task automatic t_reserved();
      reserve(32'h7000_0000);
      foreach (rsv_codes[i]) begin
         snoop(rsv_codes[i], 32'h7000_0000, 1'b1, 1'b0, 1'b1, 2'b11);
         expect_resp("R1", 1'b0, 2'b00, 1'b0, 1'b0);
         chk("R1", "reserved keeps resv", 32'(resv_valid), 32'd1);
      end
   endtask

   task automatic t_miss();
      snoop(5'b01110, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 2'b11);
      expect_resp("R9", 1'b0, 2'b00, 1'b0, 1'b0);
      snoop(5'b01010, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 2'b10);
      expect_resp("R9", 1'b0, 2'b00, 1'b0, 1'b0);
      snoop(5'b00110, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 2'b00);
      expect_resp("R9", 1'b0, 2'b00, 1'b0, 1'b0);
   endtask

   task automatic t_sc();
      @(negedge clk);
      sc_valid = 1'b1;
      @(negedge clk);
      sc_valid = 1'b0;
      chk("R11", "sc clears", 32'(resv_valid), 32'd0);
      @(negedge clk);
      lr_valid = 1'b1; lr_addr = 32'h9000_0000;
      snp_valid = 1'b1; snp_ttype = 5'b10010; tag_hit = 1'b0;
      @(negedge clk);
      lr_valid = 1'b0; snp_valid = 1'b0;
      chk("R11", "lr beats flush", 32'(resv_valid), 32'd1);
   endtask

   logic [4:0] rsv_codes [3] = '{5'b10110, 5'b00011, 5'b00111};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_kill();
      t_kill_resv();
      t_read_ci();
      t_read_other();
      t_rwitm();
      t_flush();
      t_atomic();
      t_reserved();
      t_miss();
      t_sc();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule